// File: doc/BRIEF.md
# PS/2 Host Transmit Engine

This block sends a single byte from a host controller to a PS/2 keyboard or mouse over the two open-drain PS/2 lines. A register interface hands it a byte through a valid/ready handshake. The engine first holds the bus clock low so the device stops talking. It then pulls the data line low and lets go of the clock, which asks the device to start clocking. From that point the device generates the clock. After each falling edge of that clock the engine puts the next frame bit on the data line. When the frame is complete it samples the device's acknowledge.

Each transfer ends with exactly one of three single-cycle pulses: successful completion, missing acknowledge, or clock timeout. Interrupt logic outside the block latches these pulses. Both lines are modelled as a drive-low enable output paired with a level input. The two input levels pass through a two-flop synchronizer before any decision is made on them. Cycle counts are derived from the system clock frequency parameter, so the inhibit time and the timeout are set in microseconds.

Top module: `ps2_host_tx`

## Requirements
- R1: Out of reset, both drive-low enables are inactive, `tx_ready` is high and none of the outcome pulses is asserted.
- R2: A byte is accepted at a rising clock edge where `tx_valid` and `tx_ready` are both high. In the cycle that follows, `tx_ready` is low, the clock line is driven low and the data line is released.
- R3: The clock line is driven low with data released for exactly INHIBIT_US × (CLK_HZ / 1,000,000) cycles (5000 at the defaults).
- R4: Next, data is driven low while clock stays low for REQ_CYC cycles. Then the clock line is released while data remains low, and that low level is the start bit (value 0).
- R5: Falling clock edges are counted as seen after synchronization. After falling edges 1 to 8 the data line carries data bits 0 to 7, least significant first. After edge 9 it carries the parity bit, chosen so that the nine bits hold an odd number of ones. After edge 10 it carries the stop bit (1). A bit of 0 means the line is driven low and a bit of 1 means it is released. The data line changes only after such an edge.
- R6: At falling edge 11 the data line is sampled. If it is low, `tx_done` pulses for one cycle. If it is high, `tx_nack` pulses for one cycle. In the pulse cycle both lines are released and `tx_ready` is high.
- R7: Once the clock has been released, if no clock edge is seen for TIMEOUT_US × (CLK_HZ / 1,000,000) cycles, `tx_timeout` pulses for one cycle, both lines are released and `tx_ready` returns high.
- R8: While a transfer is in progress, `tx_valid` is ignored. `tx_ready` stays low until the outcome pulse, the frame carries the byte that was accepted, and no second transfer starts.
- R9: At most one of the three outcome pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | A byte is offered for sending |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Engine idle, byte can be accepted |
| ps2_clk_i | input | 1 | Level of the PS/2 clock line |
| ps2_clk_oe | output | 1 | Drive the PS/2 clock line low |
| ps2_dat_i | input | 1 | Level of the PS/2 data line |
| ps2_dat_oe | output | 1 | Drive the PS/2 data line low |
| tx_done | output | 1 | One-cycle pulse: frame acknowledged |
| tx_nack | output | 1 | One-cycle pulse: acknowledge missing |
| tx_timeout | output | 1 | One-cycle pulse: device clock stalled |

## Verification
A wrong bit index in the shift register shows up at the device's sample point half a device clock period after the faulty falling edge, as a wrong frame bit or a wrong parity bit. A timer loaded with the wrong count changes the length of the clock-low phase or of the both-low phase before the start bit appears. It can also move the timeout pulse away from its expected cycle. A stuck or miscounting edge counter shows up as an outcome pulse at the wrong falling edge, or as no outcome pulse at all, and the device model notices this within one frame.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_INHIBIT = 2'd1,
    ST_REQ     = 2'd2,
    ST_SEND    = 2'd3
  } tx_state_e;

  localparam int unsigned FRAME_LEN = 11;

  function automatic logic odd_parity(input logic [7:0] b);
    return ~(^b);
  endfunction

  // stop, parity, data (LSB lands first), start
  function automatic logic [FRAME_LEN-1:0] build_frame(input logic [7:0] b);
    return {1'b1, odd_parity(b), b, 1'b0};
  endfunction

  function automatic int unsigned us_to_cycles(input int unsigned hz,
                                               input int unsigned us);
    return (hz / 1_000_000) * us;
  endfunction

endpackage

// File: rtl/ps2tx_line_sync.sv
module ps2tx_line_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] level_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= raw_i[g];
        sync_q <= meta_q;
      end
    end
    assign level_o[g] = sync_q;
  end
endmodule

// File: rtl/ps2tx_edge_det.sv
module ps2tx_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_i;
  end
  assign fall_o = prev_q & ~level_i;
  assign rise_o = ~prev_q & level_i;
endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned INHIBIT_US = 100,
  parameter int unsigned TIMEOUT_US = 2000,
  parameter int unsigned REQ_CYC    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  input  logic       ps2_clk_i,
  output logic       ps2_clk_oe,
  input  logic       ps2_dat_i,
  output logic       ps2_dat_oe,
  output logic       tx_done,
  output logic       tx_nack,
  output logic       tx_timeout
);
  import ps2tx_pkg::*;

  localparam int unsigned INH_CYC = us_to_cycles(CLK_HZ, INHIBIT_US);
  localparam int unsigned TMO_CYC = us_to_cycles(CLK_HZ, TIMEOUT_US);
  localparam int unsigned MAX_A   = (INH_CYC > TMO_CYC) ? INH_CYC : TMO_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > REQ_CYC) ? MAX_A : REQ_CYC;
  localparam int TW = $clog2(MAX_CYC + 1);
  localparam int CW = $clog2(FRAME_LEN + 1);

  tx_state_e            state_q;
  logic [FRAME_LEN-1:0] sr_q;
  logic [CW-1:0]        fall_cnt_q;

  // named internal events
  logic [1:0]    line_lvl;
  logic          dat_lvl;
  logic          fall_evt, rise_evt, edge_evt;
  logic          in_send, accept, last_fall, tmr_zero, timeout_evt;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;

  ps2tx_line_sync #(.N(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   ({ps2_dat_i, ps2_clk_i}),
    .level_o (line_lvl)
  );

  ps2tx_edge_det u_clk_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (line_lvl[0]),
    .fall_o  (fall_evt),
    .rise_o  (rise_evt)
  );

  ps2tx_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign dat_lvl     = line_lvl[1];
  assign edge_evt    = fall_evt | rise_evt;
  assign in_send     = (state_q == ST_SEND);
  assign tx_ready    = (state_q == ST_IDLE);
  assign accept      = tx_valid & tx_ready;
  assign last_fall   = in_send & fall_evt & (fall_cnt_q == CW'(FRAME_LEN - 1));
  assign timeout_evt = in_send & tmr_zero & ~edge_evt;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(INH_CYC - 1);
    end else if (state_q == ST_INHIBIT && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(REQ_CYC - 1);
    end else if ((state_q == ST_REQ && tmr_zero) || (in_send && edge_evt)) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(TMO_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sr_q       <= '1;
      fall_cnt_q <= '0;
      tx_done    <= 1'b0;
      tx_nack    <= 1'b0;
      tx_timeout <= 1'b0;
    end else begin
      tx_done    <= 1'b0;
      tx_nack    <= 1'b0;
      tx_timeout <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sr_q       <= build_frame(tx_data);
          fall_cnt_q <= '0;
          state_q    <= ST_INHIBIT;
        end
        ST_INHIBIT: if (tmr_zero) state_q <= ST_REQ;
        ST_REQ:     if (tmr_zero) state_q <= ST_SEND;
        ST_SEND: begin
          if (last_fall) begin
            state_q <= ST_IDLE;
            tx_done <= ~dat_lvl;
            tx_nack <= dat_lvl;
          end else if (fall_evt) begin
            sr_q       <= {1'b1, sr_q[FRAME_LEN-1:1]};
            fall_cnt_q <= fall_cnt_q + 1'b1;
          end else if (timeout_evt) begin
            state_q    <= ST_IDLE;
            tx_timeout <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ps2_clk_oe = (state_q == ST_INHIBIT) | (state_q == ST_REQ);
  assign ps2_dat_oe = (state_q == ST_REQ) | (in_send & ~sr_q[0]);

endmodule

// File: rtl/ps2_host_tx_chk.sv
module ps2_host_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic ps2_clk_oe,
  input logic ps2_dat_oe,
  input logic tx_done,
  input logic tx_nack,
  input logic tx_timeout,
  input logic in_send,
  input logic fall_evt,
  input logic edge_evt,
  input logic tmr_zero
);
  logic outcome;
  assign outcome = tx_done | tx_nack | tx_timeout;

  // R2
  accept_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (ps2_clk_oe && !ps2_dat_oe && !tx_ready));

  // R4
  release_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> ps2_dat_oe);

  // R5
  clk_free_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_send |-> !ps2_clk_oe);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_send && !fall_evt && !(tmr_zero && !edge_evt)) |=> $stable(ps2_dat_oe));

  // R6
  outcome_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outcome |-> (tx_ready && !ps2_clk_oe && !ps2_dat_oe));

  // R6
  outcome_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outcome |=> !outcome);

  // R7
  timeout_from_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_timeout |-> $past(in_send));

  // R8
  busy_until_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> outcome);

  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tx_done, tx_nack, tx_timeout}) <= 1);

endmodule

bind ps2_host_tx ps2_host_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .ps2_clk_oe (ps2_clk_oe),
  .ps2_dat_oe (ps2_dat_oe),
  .tx_done    (tx_done),
  .tx_nack    (tx_nack),
  .tx_timeout (tx_timeout),
  .in_send    (in_send),
  .fall_evt   (fall_evt),
  .edge_evt   (edge_evt),
  .tmr_zero   (tmr_zero)
);

// File: tb/sim_ps2_host_tx.sv
module sim_ps2_host_tx;
  localparam int HZ   = 1_000_000;
  localparam int INH  = 100;   // 100 us at 1 MHz
  localparam int TMO  = 2000;  // 2000 us at 1 MHz
  localparam int REQ  = 4;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_ready, ps2_clk_oe, ps2_dat_oe, tx_done, tx_nack, tx_timeout;
  logic dev_clk_low = 1'b0;
  logic dev_dat_low = 1'b0;
  logic ps2_clk_i, ps2_dat_i;

  assign ps2_clk_i = ~(ps2_clk_oe | dev_clk_low);
  assign ps2_dat_i = ~(ps2_dat_oe | dev_dat_low);

  always #5 clk = ~clk;

  ps2_host_tx #(.CLK_HZ(HZ), .INHIBIT_US(100), .TIMEOUT_US(2000), .REQ_CYC(REQ)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .ps2_clk_i(ps2_clk_i), .ps2_clk_oe(ps2_clk_oe),
    .ps2_dat_i(ps2_dat_i), .ps2_dat_oe(ps2_dat_oe), .tx_done(tx_done),
    .tx_nack(tx_nack), .tx_timeout(tx_timeout)
  );

  // modes: 0 ack, 1 no ack, 2 no device clock, 3 clock stops after 4 periods
  typedef struct { logic [7:0] data; int mode; } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  int n_done = 0, n_nack = 0, n_tmo = 0, frames_done = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (tx_done)    n_done++;
    if (tx_nack)    n_nack++;
    if (tx_timeout) n_tmo++;
  end

  // device model and monitor: pops the expected item when the host inhibits
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && ps2_clk_oe) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected transfer", 1, 0);
          while (ps2_clk_oe) @(negedge clk);
        end else begin
          exp_t it;
          int n, d0, n0, t0, ones;
          logic [9:0] got;
          it = exp_q.pop_front();
          d0 = n_done; n0 = n_nack; t0 = n_tmo;
          n = 0;
          while (ps2_clk_oe && !ps2_dat_oe) begin n++; @(negedge clk); end
          chk(n == INH, "R3 inhibit length", n, INH);
          n = 0;
          while (ps2_clk_oe && ps2_dat_oe) begin n++; @(negedge clk); end
          chk(n == REQ, "R4 request length", n, REQ);
          chk(!ps2_clk_oe && ps2_dat_i == 1'b0, "R4 start bit", int'(ps2_dat_i), 0);
          if (it.mode == 2) begin
            n = 0;
            while (n_tmo == t0 && n < TMO + 50) begin n++; @(negedge clk); end
            chk(n >= TMO && n <= TMO + 8, "R7 timeout no clock", n, TMO);
          end else begin
            int nclk;
            nclk = (it.mode == 3) ? 4 : 11;
            got = '0;
            repeat (HALF) @(negedge clk);
            for (int k = 1; k <= nclk; k++) begin
              if (k == 11 && it.mode == 0) dev_dat_low = 1'b1;
              dev_clk_low = 1'b1;
              repeat (HALF) @(negedge clk);
              dev_clk_low = 1'b0;
              if (k <= 10) got[k-1] = ps2_dat_i;
              repeat (HALF) @(negedge clk);
              dev_dat_low = 1'b0;
            end
            if (it.mode == 3) begin
              n = HALF;
              while (n_tmo == t0 && n < TMO + 50) begin n++; @(negedge clk); end
              chk(n >= TMO && n <= TMO + 8, "R7 timeout after stall", n, TMO);
            end else begin
              ones = 0;
              for (int i = 0; i < 8; i++) begin
                chk(got[i] == it.data[i], "R5 data bit", int'(got[i]), int'(it.data[i]));
                if (it.data[i]) ones++;
              end
              chk(got[8] == ((ones % 2) == 0), "R5 parity", int'(got[8]), int'((ones % 2) == 0));
              chk(got[9] == 1'b1, "R5 stop bit", int'(got[9]), 1);
              chk((n_done - d0) == (it.mode == 0 ? 1 : 0), "R6 done pulses", n_done - d0, it.mode == 0 ? 1 : 0);
              chk((n_nack - n0) == (it.mode == 1 ? 1 : 0), "R6 nack pulses", n_nack - n0, it.mode == 1 ? 1 : 0);
              chk(n_tmo == t0, "R9 no timeout with outcome", n_tmo - t0, 0);
            end
          end
          chk(!ps2_clk_oe && !ps2_dat_oe && tx_ready, "R6 R7 lines released",
              {ps2_clk_oe, ps2_dat_oe, tx_ready}, 3'b001);
          frames_done++;
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input int mode, input bit poke);
    int target, bad;
    while (!tx_ready) @(negedge clk);
    exp_q.push_back('{data: b, mode: mode});
    target = frames_done + 1;
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready && ps2_clk_oe && !ps2_dat_oe, "R2 accept",
        {tx_ready, ps2_clk_oe, ps2_dat_oe}, 3'b010);
    if (poke) begin
      repeat (30) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = 8'hC3;
      bad = 0;
      repeat (150) begin
        if (tx_ready) bad++;
        @(negedge clk);
      end
      tx_valid = 1'b0;
      chk(bad == 0, "R8 ready low while busy", bad, 0);
    end
    while (frames_done != target) @(negedge clk);
    if (poke) begin
      bad = 0;
      repeat (60) begin
        if (ps2_clk_oe) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R8 no second transfer", bad, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe && tx_ready && !tx_done && !tx_nack && !tx_timeout,
        "R1 in reset", {ps2_clk_oe, ps2_dat_oe, tx_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe && tx_ready && !tx_done && !tx_nack && !tx_timeout,
        "R1 after reset", {ps2_clk_oe, ps2_dat_oe, tx_ready}, 3'b001);
    send(8'hA5, 0, 1'b0);
    send(8'h00, 0, 1'b0);
    send(8'hFF, 0, 1'b0);
    send(8'h01, 0, 1'b0);
    send(8'h3C, 1, 1'b0);
    send(8'h80, 2, 1'b0);
    send(8'h7E, 3, 1'b0);
    send(8'h5A, 0, 1'b1);
    send(8'h96, 0, 1'b0);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule